// File: doc/BRIEF.md
# Serial Flash Status Readout Responder

This block is the device side of a status-register readout over a four-wire serial link in mode 0 (clock idles low, the host samples on rising edges). Once the select line goes low it gathers the first eight bits from the host. If they form the read-status command, it drives a two-byte status word back on the serial output, most significant bit first, for as long as the host keeps clocking. Byte 1 is followed by byte 2, then byte 1 again, and so on. Every byte is assembled from the live flag inputs at the moment its first bit is launched. The ready/busy flag occupies bit 0 of both bytes, so a host that polls continuously sees it refreshed every eight clocks.

The serial pins are sampled by a fast system clock and are assumed to be already synchronous to it. Edges of the serial clock are found by comparing it with its value one system clock earlier. The serial output comes with a separate output-enable, which the pad uses as a tri-state control. The enable is low outside a readout. It also stays low after any other command byte until the select line goes high again. The link has no data stream with flow control: the host sets the pace through the serial clock, and the flag inputs are plain levels.

Top module: `spi_status_responder`

## Requirements
- R1: With `cs_ni` low, the first eight bits on `mosi_i`, sampled at rising `sclk_i` edges and taken MSB first, equal to 0x05 start a readout. `miso_oe_o` goes high after the next falling `sclk_i` edge, and bit 7 of byte 1 is then on `miso_o`.
- R2: Any other first byte keeps `miso_oe_o` low for the rest of that selection, however many further clocks arrive.
- R3: `miso_o` and `miso_oe_o` change only after a falling `sclk_i` edge or when `cs_ni` is high. They stay constant across a rising edge.
- R4: The byte 1 bit positions are: bit 7 = `lock_i`, bit 6 = 0, bit 5 = `prog_err_i`, bit 4 = `wp_pin_i` (0 means the protect pin is asserted), bits 3:2 = `prot_sum_i`, bit 1 = `wel_i`, bit 0 = `busy_i`.
- R5: Byte 2 is `{stat2_i[6:0], busy_i}`, with busy in bit 0.
- R6: While the clock keeps running, the bytes alternate byte 1, byte 2, byte 1, and so on, each sent MSB first.
- R7: A byte is captured from the flag inputs at the falling edge that launches its bit 7. Input changes after that point do not alter the remaining bits of the byte.
- R8: When `cs_ni` goes high at any point, including mid-byte or mid-command, `miso_oe_o` is low one system clock later. The next selection decodes a fresh command from its first bit.
- R9: After reset, `miso_oe_o` is low.
- R10: Bit 0 of every byte shows `busy_i` as sampled at that byte's capture. This includes a change that arrives in the same system clock as the capturing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the host |
| busy_i | input | 1 | Internal operation in progress |
| wel_i | input | 1 | Write-enable latch state |
| prog_err_i | input | 1 | Last program or erase failed |
| wp_pin_i | input | 1 | Protect pin level, 0 = asserted |
| prot_sum_i | input | 2 | Protection summary: 00 none, 01 some, 10 reserved, 11 all |
| lock_i | input | 1 | Protection registers locked |
| stat2_i | input | 7 | Upper seven bits of byte 2 |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for `miso_o`; low means high impedance |

## Verification
Two things can fall on the same system clock: the falling edge that captures a new status byte, and a change of the busy flag. The bench toggles `busy_i` on exactly the system clock where it lowers the serial clock after the last bit of a byte. The next byte's bit 0 must show the new value, while a toggle placed mid-byte must leave the current byte unchanged. The deselect path is also tested against a falling edge in the middle of a byte. The bench checks that the enable drops within one system clock and that the next selection starts a clean decode.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned STAT_BYTE_W = 8;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_ARMED  = 2'd1,
    DEC_REJECT = 2'd2
  } dec_state_e;
endpackage

// File: rtl/spi_stat_edge.sv
module spi_stat_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/spi_stat_decoder.sv
module spi_stat_decoder
  import spi_stat_pkg::*;
#(
  parameter int unsigned CMD_W  = 8,
  parameter logic [CMD_W-1:0] OPCODE = 8'h05
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic mosi_i,
  input  logic rise_i,
  output logic armed_o,
  output logic reject_o
);
  localparam int unsigned CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  dec_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] sh_q;
  logic [CMD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[CMD_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DEC_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_ni) begin
      st_q  <= DEC_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (rise_i && st_q == DEC_IDLE) begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) st_q <= (sh_nxt == OPCODE) ? DEC_ARMED : DEC_REJECT;
    end
  end

  assign armed_o  = (st_q == DEC_ARMED);
  assign reject_o = (st_q == DEC_REJECT);

  // R2: a rejected command stays rejected until deselect
  p_reject_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == DEC_REJECT && !cs_ni) |=> st_q == DEC_REJECT);

  // R8: deselect clears the decoder
  p_idle_on_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (st_q == DEC_IDLE && cnt_q == '0));
endmodule

// File: rtl/spi_stat_shifter.sv
module spi_stat_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              fall_i,
  input  logic              armed_i,
  input  logic [BYTE_W-1:0] byte_a_i,
  input  logic [BYTE_W-1:0] byte_b_i,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int unsigned BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(BYTE_W - 1);

  logic              active_q;
  logic              sel_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [BYTE_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      bcnt_q   <= '0;
      sreg_q   <= '0;
    end else if (cs_ni) begin
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      bcnt_q   <= '0;
      sreg_q   <= '0;
    end else if (fall_i && armed_i) begin
      if (!active_q) begin
        active_q <= 1'b1;
        sel_q    <= 1'b0;
        bcnt_q   <= '0;
        sreg_q   <= byte_a_i;
      end else if (bcnt_q == LAST) begin
        sel_q  <= ~sel_q;
        bcnt_q <= '0;
        sreg_q <= sel_q ? byte_a_i : byte_b_i;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
        sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = sreg_q[BYTE_W-1];
  assign oe_o   = active_q;

  // R1: driving starts only after the command was accepted
  p_start_needs_armed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(armed_i));

  // R6: every readout begins with byte 1 at its first bit
  p_first_is_byte1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> (!sel_q && bcnt_q == '0));

  // R3: outputs move only on a falling edge or deselect
  p_hold_off_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !cs_ni) |=> ($stable(miso_o) && $stable(oe_o)));

  // R8: deselect releases the output
  p_release_on_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !oe_o);
endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder
  import spi_stat_pkg::*;
#(
  parameter logic [7:0] READ_OPCODE = 8'h05
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       busy_i,
  input  logic       wel_i,
  input  logic       prog_err_i,
  input  logic       wp_pin_i,
  input  logic [1:0] prot_sum_i,
  input  logic       lock_i,
  input  logic [6:0] stat2_i,
  output logic       miso_o,
  output logic       miso_oe_o
);
  logic                   sclk_rise, sclk_fall;
  logic                   armed, reject;
  logic [STAT_BYTE_W-1:0] byte_a, byte_b;

  spi_stat_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  spi_stat_decoder #(
    .CMD_W  (8),
    .OPCODE (READ_OPCODE)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .mosi_i   (mosi_i),
    .rise_i   (sclk_rise),
    .armed_o  (armed),
    .reject_o (reject)
  );

  // Live status words; the shifter captures them at byte start
  always_comb begin
    byte_a = {lock_i, 1'b0, prog_err_i, wp_pin_i, prot_sum_i, wel_i, busy_i};
    byte_b = {stat2_i, busy_i};
  end

  spi_stat_shifter #(
    .BYTE_W (STAT_BYTE_W)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .fall_i   (sclk_fall),
    .armed_i  (armed),
    .byte_a_i (byte_a),
    .byte_b_i (byte_b),
    .miso_o   (miso_o),
    .oe_o     (miso_oe_o)
  );

  // R2: a rejected command never drives the output
  p_reject_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |-> !miso_oe_o);

  // R9: output released right after reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r9: assert (!miso_oe_o);
  end
endmodule

// File: tb/spi_status_responder_bench.sv
module spi_status_responder_bench;
  localparam int H = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       busy = 1'b0, wel = 1'b0, err = 1'b0, wp = 1'b1, lock = 1'b0;
  logic [1:0] prot = 2'b00;
  logic [6:0] stat2 = 7'h00;
  logic       miso, oe;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  spi_status_responder u_spi_status_responder (
    .clk_i (clk), .rst_ni (rst_n), .sclk_i (sclk), .cs_ni (cs_n), .mosi_i (mosi),
    .busy_i (busy), .wel_i (wel), .prog_err_i (err), .wp_pin_i (wp),
    .prot_sum_i (prot), .lock_i (lock), .stat2_i (stat2),
    .miso_o (miso), .miso_oe_o (oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one serial bit; samples miso before the rising edge, flips busy at the fall if asked
  task automatic xfer(input logic b, input bit flip, output logic o, output logic en, output bit same);
    mosi = b;
    repeat (H) @(negedge clk);
    o = miso; en = oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    same = (miso === o) && (oe === en);
    sclk = 1'b0;
    if (flip) busy = ~busy;
  endtask

  task automatic select_dev();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect_dev();
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, output int oe_seen);
    logic o, en; bit s;
    oe_seen = 0;
    for (int i = 7; i > 7 - n; i--) begin
      xfer(v[i], 1'b0, o, en, s);
      if (en) oe_seen++;
    end
  endtask

  task automatic read_byte(input int flip_at, output logic [7:0] v, output int oe_cnt, output bit all_same);
    logic o, en; bit s;
    oe_cnt = 0; all_same = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xfer(1'b0, (i == flip_at), o, en, s);
      v[i] = o;
      if (en === 1'b1) oe_cnt++;
      if (!s) all_same = 1'b0;
    end
  endtask

  function automatic logic [7:0] exp_b1();
    return {lock, 1'b0, err, wp, prot, wel, busy};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b1, b2, b3, e1, e2;
    int cnt, cnt2;
    bit s1, s2, s3;

    repeat (3) @(negedge clk);
    chk(oe === 1'b0, "R9 reset enable", 32'(oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(oe === 1'b0, "R9 enable after reset", 32'(oe), 0);

    // R1/R2: every command byte
    for (int op = 0; op < 256; op++) begin
      select_dev();
      send_bits(8'(op), 8, cnt);
      chk(cnt == 0, "R1 quiet during command", 32'(cnt), 0);
      read_byte(-1, b1, cnt2, s1);
      if (op == 5) chk(cnt2 == 8, "R1 drives after read command", 32'(cnt2), 8);
      else         chk(cnt2 == 0, "R2 other command stays quiet", 32'(cnt2), 0);
      deselect_dev();
    end

    // R3/R4/R5/R6: all byte-1 flag combinations
    for (int k = 0; k < 128; k++) begin
      busy = k[0]; wel = k[1]; prot = 2'(k >> 2); wp = k[4]; err = k[5]; lock = k[6];
      stat2 = 7'(k * 37 + 11);
      e1 = exp_b1();
      e2 = {stat2, busy};
      select_dev();
      send_bits(8'h05, 8, cnt);
      read_byte(-1, b1, cnt, s1);
      read_byte(-1, b2, cnt, s2);
      read_byte(-1, b3, cnt, s3);
      chk(b1 == e1, "R4 byte 1 layout", 32'(b1), 32'(e1));
      chk(b2 == e2, "R5 byte 2 layout", 32'(b2), 32'(e2));
      chk(b3 == e1, "R6 wrap to byte 1", 32'(b3), 32'(e1));
      chk(s1 && s2 && s3, "R3 stable across rising edge", 32'({s1, s2, s3}), 32'h7);
      deselect_dev();
    end

    // R7/R10: mid-byte change kept out; same-cycle change at capture taken in
    busy = 1'b0; wel = 1'b1; prot = 2'b01; wp = 1'b0; err = 1'b0; lock = 1'b1; stat2 = 7'h55;
    e1 = exp_b1();
    select_dev();
    send_bits(8'h05, 8, cnt);
    read_byte(5, b1, cnt, s1);
    chk(b1 == e1, "R7 byte held after mid-byte change", 32'(b1), 32'(e1));
    e2 = {stat2, 1'b1};
    read_byte(0, b2, cnt, s2);
    chk(b2 == e2, "R10 busy refreshed in byte 2", 32'(b2), 32'(e2));
    e1 = exp_b1();
    read_byte(-1, b3, cnt, s3);
    chk(b3 == e1, "R10 same-cycle busy change captured", 32'(b3), 32'(e1));
    chk(b3[0] == 1'b0, "R10 busy bit of third byte", 32'(b3[0]), 0);
    deselect_dev();

    // R8: deselect mid-byte
    select_dev();
    send_bits(8'h05, 8, cnt);
    send_bits(8'h00, 3, cnt);
    chk(cnt == 3, "R8 driving before deselect", 32'(cnt), 3);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk(oe === 1'b0, "R8 released one clock after deselect", 32'(oe), 0);
    repeat (2) @(negedge clk);

    // R8: aborted command then fresh decode
    select_dev();
    send_bits(8'h05, 4, cnt);
    deselect_dev();
    select_dev();
    send_bits(8'h05, 8, cnt);
    e1 = exp_b1();
    read_byte(-1, b1, cnt, s1);
    chk(b1 == e1 && cnt == 8, "R8 fresh decode after abort", 32'(b1), 32'(e1));
    deselect_dev();

    // R2: command fragment followed by junk after a rejected byte
    select_dev();
    send_bits(8'h85, 8, cnt);
    send_bits(8'h05, 8, cnt);
    read_byte(-1, b1, cnt2, s1);
    chk(cnt == 0 && cnt2 == 0, "R2 no restart within selection", 32'(cnt + cnt2), 0);
    deselect_dev();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule